// File: doc/BRIEF.md
# Reset and Machine-Check Exception Entry Controller

This block decides when a 32-bit processor core enters one of two exceptions: a system reset started from an asynchronous soft-reset pin, or a machine check raised from an external pin or from a group of internal error flags. When it accepts an exception, it saves the next-instruction address and a filtered copy of the machine state word into two save registers. It then rewrites the state word and sends a one-cycle redirect with a flush to the exception vector. The vector base is chosen by the prefix bit of the state word.

A machine check is taken only while the state word's machine-check-enable bit is set. If that bit is clear, a machine check instead latches a checkstop that stops all further exception entry until hard reset. The block also holds a sticky software flag that is cleared only by hard reset. Software sets it after power-up and reads it later to tell a hard reset from a soft one. Instruction fetch, the error detectors and the return path are outside the block: they appear only as plain ports, including a write port for the state word.

Top module: `exc_entry_ctrl`

## Requirements
- R1: During hard reset (`rst_n` low at a clock edge) the state word becomes 0x00000040, both save registers become 0, and redirect, flush, checkstop and the sticky flag all become 0.
- R2: The soft-reset pin is synchronised through two flops. An entry occurs only if the synchronised level stays high for at least `sr_min_width_i` consecutive cycles (a value of 0 counts as 1). With first pin sample at edge k and width N, the redirect is visible after edge k+N+1. Shorter pulses cause no entry.
- R3: One soft-reset assertion causes at most one entry, however long the pin is held.
- R4: A qualifying soft-reset edge is dropped without entry if `test_busy_i` or `hrst_seq_i` is high in the cycle it qualifies.
- R5: A machine-check request is `mchk_pin_i` or any bit of `err_flags_i`. Bit 0 is bus error, 1 is address parity, 2 is data parity, 3 is second-level bus parity, 4 is instruction cache, 5 is data cache, 6 is second-level tag. With enable (state bit 12 counted from the LSB) set, the request is taken at the edge that samples it, with offset 0x200.
- R6: A machine-check request while enable is clear sets `checkstop_o` at that edge, without a redirect and without changing the state word. Checkstop holds until hard reset, and while it is set no exception of either kind is entered.
- R7: If a machine check and a qualifying soft reset occur in the same cycle, the machine check is taken and the soft-reset edge is dropped.
- R8: On entry, save register 0 receives `next_pc_i`.
- R9: On entry, save register 1 receives the old state word ANDed with 0x0200FFFF. Bit 1 counted from the LSB is also forced to 0 when `unrecov_i` is high.
- R10: On entry, state bit 0 is loaded from old bit 16. Bits 25, 18, 15 to 8, 6, 5, 4, 2 and 1 are cleared. All other bits keep their value.
- R11: The vector address is the offset (0x100 for soft reset, 0x200 for machine check) plus a base. The base is 0xFFF00000 when old state bit 6 is set and 0 otherwise.
- R12: `redirect_vld_o` and `flush_o` are high together for exactly one cycle per entry.
- R13: `nhr_o` is set by `nhr_set_i`, is cleared only by hard reset, and is unchanged by exception entry.
- R14: `msr_wr_en_i` loads `msr_wr_data_i` into the state word at the next edge. An entry in the same cycle takes precedence over the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low hard reset |
| sreset_pin_i | input | 1 | Asynchronous soft-reset request, active high |
| sr_min_width_i | input | CNT_W | Minimum synchronised soft-reset width in cycles |
| hrst_seq_i | input | 1 | Hard-reset sequence still in progress |
| test_busy_i | input | 1 | Test logic busy |
| mchk_pin_i | input | 1 | External machine-check request |
| err_flags_i | input | NUM_ERR | Internal error flags |
| next_pc_i | input | 32 | Address of the next instruction to execute |
| unrecov_i | input | 1 | Processor state is not recoverable |
| msr_wr_en_i | input | 1 | State word write enable |
| msr_wr_data_i | input | 32 | State word write data |
| nhr_set_i | input | 1 | Set the sticky not-hard-reset flag |
| msr_o | output | 32 | Machine state word |
| srr0_o | output | 32 | Save register 0 |
| srr1_o | output | 32 | Save register 1 |
| redirect_vld_o | output | 1 | Exception redirect pulse |
| redirect_addr_o | output | 32 | Vector address |
| flush_o | output | 1 | Pipeline flush pulse |
| checkstop_o | output | 1 | Checkstop state |
| nhr_o | output | 1 | Sticky not-hard-reset flag |

## Verification
A machine-check source driven in one cycle shows its result (redirect, save registers, new state word, or checkstop) after the single edge that samples it. State-word writes and the sticky flag follow the same one-edge rule. A soft-reset pulse first sampled at edge k with width N produces its redirect after edge k+N+1. The bench counts edges from the first pin sample and requires the pulse at exactly that index, and it counts redirects over a wider window to catch duplicate or missing entries. Inputs change at the falling edge and outputs are sampled at the falling edge after the counted rising edges. The priority case is built by timing a machine-check pulse to land at the edge where the soft reset would register.

// File: rtl/exc_entry_pkg.sv
// Package: shared constants for the exception entry controller.
// Bit indices are LSB-based positions inside the 32-bit machine state word.
package exc_entry_pkg;

    localparam int unsigned WORD_W      = 32;
    localparam int unsigned NUM_ERR_SRC = 7;

    // State word field positions (LSB = 0)
    localparam int unsigned ST_VECU  = 25;
    localparam int unsigned ST_SLEEP = 18;
    localparam int unsigned ST_ILEND = 16;
    localparam int unsigned ST_XIE   = 15;
    localparam int unsigned ST_USER  = 14;
    localparam int unsigned ST_FPEN  = 13;
    localparam int unsigned ST_MCEN  = 12;
    localparam int unsigned ST_FPM0  = 11;
    localparam int unsigned ST_STEP  = 10;
    localparam int unsigned ST_BTRC  = 9;
    localparam int unsigned ST_FPM1  = 8;
    localparam int unsigned ST_PFX   = 6;
    localparam int unsigned ST_ITR   = 5;
    localparam int unsigned ST_DTR   = 4;
    localparam int unsigned ST_PMK   = 2;
    localparam int unsigned ST_RCV   = 1;
    localparam int unsigned ST_LEND  = 0;

    localparam logic [WORD_W-1:0] ST_HARD_RESET = 32'h0000_0040;
    localparam logic [WORD_W-1:0] VEC_BASE_HI   = 32'hFFF0_0000;
    localparam logic [WORD_W-1:0] VEC_OFF_SRST  = 32'h0000_0100;
    localparam logic [WORD_W-1:0] VEC_OFF_MCHK  = 32'h0000_0200;

    typedef enum logic [1:0] {
        EXC_NONE = 2'd0,
        EXC_SRST = 2'd1,
        EXC_MCHK = 2'd2
    } exc_kind_e;

    // Bits of the old state word copied into save register 1
    function automatic logic [WORD_W-1:0] save_keep_mask();
        logic [WORD_W-1:0] m;
        m = '0;
        for (int i = 0; i < 16; i++) m[i] = 1'b1;
        m[ST_VECU] = 1'b1;
        return m;
    endfunction

    // Bits of the state word forced to zero on exception entry
    function automatic logic [WORD_W-1:0] entry_clear_mask();
        logic [WORD_W-1:0] m;
        m = '0;
        m[ST_VECU] = 1'b1;  m[ST_SLEEP] = 1'b1; m[ST_XIE]  = 1'b1;
        m[ST_USER] = 1'b1;  m[ST_FPEN]  = 1'b1; m[ST_MCEN] = 1'b1;
        m[ST_FPM0] = 1'b1;  m[ST_STEP]  = 1'b1; m[ST_BTRC] = 1'b1;
        m[ST_FPM1] = 1'b1;  m[ST_PFX]   = 1'b1; m[ST_ITR]  = 1'b1;
        m[ST_DTR]  = 1'b1;  m[ST_PMK]   = 1'b1; m[ST_RCV]  = 1'b1;
        m[ST_LEND] = 1'b1;
        return m;
    endfunction

    localparam logic [WORD_W-1:0] SAVE_KEEP   = save_keep_mask();
    localparam logic [WORD_W-1:0] ENTRY_CLEAR = entry_clear_mask();

endpackage

// File: rtl/exc_sreset_filter.sv
// Module: exc_sreset_filter
// Synchronises the asynchronous soft-reset pin and emits a single-cycle
// fire pulse once the synchronised level has been high for the
// programmed minimum width. Assumes the pin is free of glitches shorter
// than one clock period, or that such glitches may be lost.
module exc_sreset_filter #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin_async_i,
    input  logic [CNT_W-1:0] min_width_i,
    output logic             fire_o
);

    logic             sync1_q, sync2_q;
    logic [CNT_W-1:0] width_cnt_q;
    logic [CNT_W-1:0] target;
    logic [CNT_W:0]   cnt_inc;

    // Two-flop synchroniser for the asynchronous pin
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1_q <= 1'b0;
            sync2_q <= 1'b0;
        end else begin
            sync1_q <= pin_async_i;
            sync2_q <= sync1_q;
        end
    end

    // Minimum width of zero behaves as one cycle
    always_comb begin
        target  = (min_width_i == '0) ? {{(CNT_W-1){1'b0}}, 1'b1} : min_width_i;
        cnt_inc = {1'b0, width_cnt_q} + {{CNT_W{1'b0}}, 1'b1};
        fire_o  = sync2_q && (cnt_inc == {1'b0, target});
    end

    // Count high cycles, saturating at the target so only one fire occurs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            width_cnt_q <= '0;
        end else if (!sync2_q) begin
            width_cnt_q <= '0;
        end else if (width_cnt_q != target) begin
            width_cnt_q <= cnt_inc[CNT_W-1:0];
        end
    end

    assert_one_fire_per_assert_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fire_o |=> !fire_o);

    assert_fire_after_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_o && min_width_i > 1 && $stable(min_width_i)) |-> $past(sync2_q));

endmodule

// File: rtl/exc_mchk_gate.sv
// Module: exc_mchk_gate
// Merges the machine-check pin with the internal error flags, gates the
// result with the state word's enable bit and latches checkstop when a
// request arrives with the enable clear. Assumes flags are level signals
// already aligned to clk.
module exc_mchk_gate #(
    parameter int unsigned NUM_ERR = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pin_i,
    input  logic [NUM_ERR-1:0] err_i,
    input  logic               mcen_i,
    output logic               req_o,
    output logic               take_o,
    output logic               checkstop_o
);

    logic stop_q;

    // Request, acceptance and checkstop trigger
    always_comb begin
        req_o  = pin_i || (|err_i);
        take_o = req_o && mcen_i && !stop_q;
    end

    // Checkstop latch, released only by hard reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stop_q <= 1'b0;
        end else if (req_o && !mcen_i) begin
            stop_q <= 1'b1;
        end
    end

    assign checkstop_o = stop_q;

    assert_checkstop_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        checkstop_o |=> checkstop_o);

    assert_checkstop_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(checkstop_o) |-> $past(!mcen_i && req_o));

endmodule

// File: rtl/exc_entry_regs.sv
// Module: exc_entry_regs
// Holds the machine state word and both save registers, performs the
// entry rewrite and produces the registered redirect and flush pulse.
// Assumes at most one take input is high per cycle (the top resolves
// priority).
module exc_entry_regs
    import exc_entry_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take_srst_i,
    input  logic              take_mchk_i,
    input  logic [WORD_W-1:0] next_pc_i,
    input  logic              unrecov_i,
    input  logic              msr_wr_en_i,
    input  logic [WORD_W-1:0] msr_wr_data_i,
    output logic [WORD_W-1:0] msr_o,
    output logic [WORD_W-1:0] srr0_o,
    output logic [WORD_W-1:0] srr1_o,
    output logic              redir_vld_o,
    output logic [WORD_W-1:0] redir_addr_o,
    output logic              flush_o
);

    exc_kind_e         kind;
    logic [WORD_W-1:0] msr_q, srr0_q, srr1_q, addr_q;
    logic              vld_q;
    logic [WORD_W-1:0] msr_next, srr1_next, vec_base, vec_off;

    // Select exception kind; machine check wins
    always_comb begin
        if (take_mchk_i)      kind = EXC_MCHK;
        else if (take_srst_i) kind = EXC_SRST;
        else                  kind = EXC_NONE;
    end

    // Compute the rewritten state word, save value and vector
    always_comb begin
        msr_next            = msr_q & ~ENTRY_CLEAR;
        msr_next[ST_LEND]   = msr_q[ST_ILEND];
        srr1_next           = msr_q & SAVE_KEEP;
        if (unrecov_i) srr1_next[ST_RCV] = 1'b0;
        vec_base            = msr_q[ST_PFX] ? VEC_BASE_HI : '0;
        vec_off             = (kind == EXC_MCHK) ? VEC_OFF_MCHK : VEC_OFF_SRST;
    end

    // State word, save registers and redirect pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msr_q  <= ST_HARD_RESET;
            srr0_q <= '0;
            srr1_q <= '0;
            vld_q  <= 1'b0;
            addr_q <= '0;
        end else if (kind != EXC_NONE) begin
            msr_q  <= msr_next;
            srr0_q <= next_pc_i;
            srr1_q <= srr1_next;
            vld_q  <= 1'b1;
            addr_q <= vec_base | vec_off;
        end else begin
            vld_q <= 1'b0;
            if (msr_wr_en_i) msr_q <= msr_wr_data_i;
        end
    end

    assign msr_o        = msr_q;
    assign srr0_o       = srr0_q;
    assign srr1_o       = srr1_q;
    assign redir_vld_o  = vld_q;
    assign redir_addr_o = addr_q;
    assign flush_o      = vld_q;

    assert_entry_disables_mchk_R10: assert property (@(posedge clk) disable iff (!rst_n)
        redir_vld_o |-> !msr_o[ST_MCEN]);

    assert_srr1_zero_fields_R9: assert property (@(posedge clk) disable iff (!rst_n)
        redir_vld_o |-> ((srr1_o & ~SAVE_KEEP) == '0));

    assert_vector_shape_R11: assert property (@(posedge clk) disable iff (!rst_n)
        redir_vld_o |-> ((redir_addr_o[19:0] == 20'h00100 || redir_addr_o[19:0] == 20'h00200)
                         && (redir_addr_o[31:20] == 12'h000 || redir_addr_o[31:20] == 12'hFFF)));

    assert_srr0_captured_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (take_srst_i || take_mchk_i) |=> (srr0_o == $past(next_pc_i)));

endmodule

// File: rtl/exc_entry_ctrl.sv
// Module: exc_entry_ctrl (top)
// Exception entry controller: resolves hard reset, machine check and
// soft reset priority, drives the entry registers and keeps the sticky
// not-hard-reset flag. Assumes rst_n is synchronous to clk.
module exc_entry_ctrl
    import exc_entry_pkg::*;
#(
    parameter int unsigned CNT_W   = 8,
    parameter int unsigned NUM_ERR = NUM_ERR_SRC
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sreset_pin_i,
    input  logic [CNT_W-1:0]   sr_min_width_i,
    input  logic               hrst_seq_i,
    input  logic               test_busy_i,
    input  logic               mchk_pin_i,
    input  logic [NUM_ERR-1:0] err_flags_i,
    input  logic [31:0]        next_pc_i,
    input  logic               unrecov_i,
    input  logic               msr_wr_en_i,
    input  logic [31:0]        msr_wr_data_i,
    input  logic               nhr_set_i,
    output logic [31:0]        msr_o,
    output logic [31:0]        srr0_o,
    output logic [31:0]        srr1_o,
    output logic               redirect_vld_o,
    output logic [31:0]        redirect_addr_o,
    output logic               flush_o,
    output logic               checkstop_o,
    output logic               nhr_o
);

    logic sr_fire, mchk_req, mchk_take, take_srst, nhr_q;

    exc_sreset_filter #(.CNT_W(CNT_W)) u_sr_filter (
        .clk         (clk),
        .rst_n       (rst_n),
        .pin_async_i (sreset_pin_i),
        .min_width_i (sr_min_width_i),
        .fire_o      (sr_fire)
    );

    exc_mchk_gate #(.NUM_ERR(NUM_ERR)) u_mchk_gate (
        .clk         (clk),
        .rst_n       (rst_n),
        .pin_i       (mchk_pin_i),
        .err_i       (err_flags_i),
        .mcen_i      (msr_o[ST_MCEN]),
        .req_o       (mchk_req),
        .take_o      (mchk_take),
        .checkstop_o (checkstop_o)
    );

    // Soft reset qualifies only when nothing higher or blocking is active
    always_comb begin
        take_srst = sr_fire && !hrst_seq_i && !test_busy_i
                    && !checkstop_o && !mchk_req;
    end

    exc_entry_regs u_entry_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .take_srst_i   (take_srst),
        .take_mchk_i   (mchk_take),
        .next_pc_i     (next_pc_i),
        .unrecov_i     (unrecov_i),
        .msr_wr_en_i   (msr_wr_en_i),
        .msr_wr_data_i (msr_wr_data_i),
        .msr_o         (msr_o),
        .srr0_o        (srr0_o),
        .srr1_o        (srr1_o),
        .redir_vld_o   (redirect_vld_o),
        .redir_addr_o  (redirect_addr_o),
        .flush_o       (flush_o)
    );

    // Sticky flag: software sets, only hard reset clears
    always_ff @(posedge clk) begin
        if (!rst_n)         nhr_q <= 1'b0;
        else if (nhr_set_i) nhr_q <= 1'b1;
    end

    assign nhr_o = nhr_q;

    assert_nhr_sticky_R13: assert property (@(posedge clk) disable iff (!rst_n)
        nhr_o |=> nhr_o);

    assert_quiet_in_checkstop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        checkstop_o |=> !redirect_vld_o);

    assert_srst_not_blocked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect_vld_o && redirect_addr_o[9:8] == 2'b01) |-> $past(!test_busy_i && !hrst_seq_i));

    assert_mchk_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mchk_req && sr_fire && !checkstop_o && msr_o[ST_MCEN]) |=> (redirect_addr_o[9:8] == 2'b10));

endmodule

// File: tb/tb_exc_entry_ctrl.sv
// Bench for exc_entry_ctrl: table-driven machine-check vectors, then
// directed tests for reset, soft-reset filtering, blocking and priority.
module tb_exc_entry_ctrl;

    localparam int CNT_W = 8;
    localparam int NERR  = 7;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              sreset_pin = 1'b0;
    logic [CNT_W-1:0]  sr_min_width = 8'd1;
    logic              hrst_seq = 1'b0;
    logic              test_busy = 1'b0;
    logic              mchk_pin = 1'b0;
    logic [NERR-1:0]   err_flags = '0;
    logic [31:0]       next_pc = 32'h0000_3000;
    logic              unrecov = 1'b0;
    logic              msr_wr_en = 1'b0;
    logic [31:0]       msr_wr_data = '0;
    logic              nhr_set = 1'b0;
    logic [31:0]       msr, srr0, srr1, raddr;
    logic              rvld, flush, cstop, nhr;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    exc_entry_ctrl #(.CNT_W(CNT_W), .NUM_ERR(NERR)) dut (
        .clk(clk), .rst_n(rst_n), .sreset_pin_i(sreset_pin),
        .sr_min_width_i(sr_min_width), .hrst_seq_i(hrst_seq),
        .test_busy_i(test_busy), .mchk_pin_i(mchk_pin),
        .err_flags_i(err_flags), .next_pc_i(next_pc), .unrecov_i(unrecov),
        .msr_wr_en_i(msr_wr_en), .msr_wr_data_i(msr_wr_data),
        .nhr_set_i(nhr_set), .msr_o(msr), .srr0_o(srr0), .srr1_o(srr1),
        .redirect_vld_o(rvld), .redirect_addr_o(raddr), .flush_o(flush),
        .checkstop_o(cstop), .nhr_o(nhr)
    );

    typedef struct packed {
        logic [31:0] msr;
        logic        pin;
        logic [6:0]  flags;
        logic        unrec;
        logic [31:0] pc;
        logic        exp_vld;
        logic        exp_stop;
        logic [31:0] exp_addr;
    } vec_t;

    // Machine-check vectors (R5, R6, R9, R10, R11)
    localparam vec_t VECS [10] = '{
        '{32'h0000_1000, 1'b1, 7'h00, 1'b0, 32'h0000_0104, 1'b1, 1'b0, 32'h0000_0200},
        '{32'h0000_1040, 1'b0, 7'h01, 1'b0, 32'h0001_0000, 1'b1, 1'b0, 32'hFFF0_0200},
        '{32'hFFFF_FFFF, 1'b0, 7'h02, 1'b1, 32'h8000_0000, 1'b1, 1'b0, 32'hFFF0_0200},
        '{32'h0001_1001, 1'b0, 7'h04, 1'b0, 32'h0000_0ABC, 1'b1, 1'b0, 32'h0000_0200},
        '{32'h0200_1000, 1'b0, 7'h08, 1'b0, 32'h1234_5678, 1'b1, 1'b0, 32'h0000_0200},
        '{32'h0000_1002, 1'b0, 7'h10, 1'b1, 32'h0000_0010, 1'b1, 1'b0, 32'h0000_0200},
        '{32'h0000_F000, 1'b0, 7'h20, 1'b0, 32'h0000_0020, 1'b1, 1'b0, 32'h0000_0200},
        '{32'h0000_1000, 1'b0, 7'h40, 1'b0, 32'h0000_0030, 1'b1, 1'b0, 32'h0000_0200},
        '{32'h0000_0000, 1'b1, 7'h00, 1'b0, 32'h0000_0040, 1'b0, 1'b1, 32'h0000_0000},
        '{32'hFFFF_EFFF, 1'b0, 7'h08, 1'b0, 32'h0000_0050, 1'b0, 1'b1, 32'h0000_0000}
    };

    // Expected state word after entry (R10)
    function automatic logic [31:0] exp_msr(input logic [31:0] old);
        logic [31:0] r;
        r    = old & ~32'h0204_FF77;
        r[0] = old[16];
        return r;
    endfunction

    // Expected save register 1 (R9)
    function automatic logic [31:0] exp_srr1(input logic [31:0] old, input logic unr);
        logic [31:0] r;
        r = old & 32'h0200_FFFF;
        if (unr) r[1] = 1'b0;
        return r;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic hard_reset();
        rst_n = 1'b0;
        tick();
        tick();
        rst_n = 1'b1;
    endtask

    task automatic write_msr(input logic [31:0] v);
        msr_wr_en   = 1'b1;
        msr_wr_data = v;
        tick();
        msr_wr_en   = 1'b0;
    endtask

    // Hold the soft-reset pin for 'hold' edges, observe 'win' edges
    task automatic sr_run(input int hold, input int win,
                          output int cnt, output int at, output logic [31:0] addr);
        cnt = 0; at = -1; addr = '0;
        sreset_pin = 1'b1;
        for (int i = 1; i <= win; i++) begin
            tick();
            if (i == hold) sreset_pin = 1'b0;
            if (rvld) begin
                cnt++;
                if (at < 0) begin at = i; addr = raddr; end
            end
        end
        sreset_pin = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        int cnt, at;
        logic [31:0] a;
        logic [31:0] m0;

        // R1: reset state
        @(negedge clk);
        hard_reset();
        chk("R1 msr", msr, 32'h0000_0040);
        chk("R1 srr0", srr0, '0);
        chk("R1 srr1", srr1, '0);
        chk("R1 vld/flush/stop/nhr", {28'd0, rvld, flush, cstop, nhr}, '0);

        // Table walk: machine-check sources
        foreach (VECS[k]) begin
            hard_reset();
            write_msr(VECS[k].msr);
            next_pc   = VECS[k].pc;
            unrecov   = VECS[k].unrec;
            mchk_pin  = VECS[k].pin;
            err_flags = VECS[k].flags;
            tick();
            mchk_pin = 1'b0; err_flags = '0; unrecov = 1'b0;
            chk("R5 R12 vld", {31'd0, rvld}, {31'd0, VECS[k].exp_vld});
            chk("R12 flush", {31'd0, flush}, {31'd0, VECS[k].exp_vld});
            chk("R6 checkstop", {31'd0, cstop}, {31'd0, VECS[k].exp_stop});
            if (VECS[k].exp_vld) begin
                chk("R11 vector", raddr, VECS[k].exp_addr);
                chk("R8 srr0", srr0, VECS[k].pc);
                chk("R9 srr1", srr1, exp_srr1(VECS[k].msr, VECS[k].unrec));
                chk("R10 msr", msr, exp_msr(VECS[k].msr));
            end else begin
                chk("R6 msr unchanged", msr, VECS[k].msr);
            end
            tick();
            chk("R12 single pulse", {31'd0, rvld}, '0);
        end

        // R2/R3/R8/R13: soft reset filtering
        hard_reset();
        m0 = 32'h0001_D0F3;
        write_msr(m0);
        nhr_set = 1'b1; tick(); nhr_set = 1'b0;
        sr_min_width = 8'd4;
        next_pc = 32'h0000_7778;
        sr_run(3, 12, cnt, at, a);
        chk("R2 short pulse ignored", cnt, 0);
        sr_run(10, 20, cnt, at, a);
        chk("R3 one entry", cnt, 1);
        chk("R2 latency", at, 6);
        chk("R11 soft vector", a, 32'hFFF0_0100);
        chk("R8 srr0 soft", srr0, 32'h0000_7778);
        chk("R9 srr1 soft", srr1, exp_srr1(m0, 1'b0));
        chk("R10 msr soft", msr, exp_msr(m0));
        chk("R13 nhr survives soft reset", {31'd0, nhr}, 32'd1);

        // R4: blocked by test busy and by hard-reset sequence
        test_busy = 1'b1;
        sr_run(10, 20, cnt, at, a);
        test_busy = 1'b0;
        chk("R4 test busy blocks", cnt, 0);
        hrst_seq = 1'b1;
        sr_run(10, 20, cnt, at, a);
        hrst_seq = 1'b0;
        chk("R4 hard seq blocks", cnt, 0);

        // R7: machine check and soft reset in the same cycle
        hard_reset();
        write_msr(32'h0000_1000);
        sr_min_width = 8'd1;
        sreset_pin = 1'b1;
        tick();
        tick();
        mchk_pin = 1'b1;
        tick();
        mchk_pin = 1'b0;
        sreset_pin = 1'b0;
        chk("R7 mchk wins", raddr, 32'h0000_0200);
        cnt = 0;
        for (int i = 0; i < 10; i++) begin
            tick();
            if (rvld) cnt++;
        end
        chk("R7 soft edge dropped", cnt, 0);

        // R6: checkstop blocks further entry until hard reset
        hard_reset();
        nhr_set = 1'b1; tick(); nhr_set = 1'b0;
        err_flags = 7'h20;
        tick();
        err_flags = '0;
        chk("R6 enters checkstop", {31'd0, cstop}, 32'd1);
        sr_run(10, 20, cnt, at, a);
        chk("R6 no soft entry in checkstop", cnt, 0);
        chk("R6 checkstop held", {31'd0, cstop}, 32'd1);
        hard_reset();
        chk("R6 hard reset clears checkstop", {31'd0, cstop}, '0);
        chk("R13 hard reset clears nhr", {31'd0, nhr}, '0);

        // R14: state word write and entry precedence
        write_msr(32'h1234_5678);
        chk("R14 write", msr, 32'h1234_5678);
        msr_wr_en = 1'b1; msr_wr_data = 32'hAAAA_0000; mchk_pin = 1'b1;
        tick();
        msr_wr_en = 1'b0; mchk_pin = 1'b0;
        chk("R14 entry beats write", msr, exp_msr(32'h1234_5678));

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule